// File: doc/BRIEF.md
# Counter/Timer Image Transfer Controller

This block holds four 16-bit counter channels. Each channel is paired with an image register and has a 3-bit mode. Software asks for a transfer between a counter and its image by setting that channel's bit in a request register. The channel's mode decides which way the data moves. In the countdown-style modes (waveform, pulse, watchdog) the image is copied into the counter. In the accumulating modes (event count, time capture) the counter is copied into the image. Channel 2 is built without the store path, so its request always loads.

A write to the request register is only accepted while the permission bit in the command register is set. Each channel clears its own request bit on the edge where it performs the transfer, so software can poll the request register to see when the transfer is done. Between transfers, each counter counts on a shared tick input.

Top module: `ctimg_ctrl`

## Requirements
- R1: After reset (rst_n low at a clock edge), every counter, image register, mode field, request bit and the command register read as 0.
- R2: A write to the request register (address 1) when command bit 6 is 0 leaves the request bits unchanged. Command address 0 reads back only bit 6.
- R3: In modes 2 (waveform), 3 (pulse) and 4 (watchdog), a pending request copies the image register into the counter on the next clock edge.
- R4: On channels 0, 1 and 3, in modes 0 (event count) and 1 (time capture), a pending request copies the counter into the image register on the next clock edge. The counter keeps its value.
- R5: Channel 2 never stores. A pending request in any valid mode, 0 or 1 included, loads its counter from its image, and its image register keeps its value.
- R6: A request bit written as 1 reads 1 in the cycle after the write. In a valid mode it reads 0 from the cycle after the transfer edge.
- R7: Modes 5 to 7 are invalid. While a channel's mode is invalid it performs no transfer, does not count, and keeps its request bit pending. The transfer is served on the first edge after a valid mode is written.
- R8: On tick = 1, counters in modes 2 to 4 decrement and counters in modes 0 and 1 increment.
- R9: If a transfer and a tick fall on the same edge, the counter takes the transferred value and ignores the tick.
- R10: Address map: 0 command, 1 request, 2 to 5 mode of channels 0 to 3, 6 to 9 image of channels 0 to 3, 10 to 13 counter of channels 0 to 3 (read only). The request register reads its bits 0 to 3 as channels 0 to 3, with bits 15 to 4 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (read and write) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| tick | input | 1 | Count enable for all channels |

## Verification
The bound checker watches several properties on every cycle:
- the permission gate on request writes;
- automatic clearing of served request bits;
- the load and store data paths per channel;
- the fact that channel 2's image can change only through a host write;
- the freeze of counters in invalid modes.

Other behaviours depend on ordering and are shown only by the bench scenarios:
- a request that stays pending across a mode change;
- the priority of a transfer over a simultaneous tick;
- the read-back encoding of the request and command registers.

// File: rtl/ctimg_pkg.sv
// Shared constants, mode encoding and decode helpers for the counter/timer
// image transfer controller. Assumes a 4-bit register address space.
package ctimg_pkg;
    localparam int NCH    = 4;
    localparam int CW     = 16;
    localparam int AW     = 4;
    localparam int MW     = 3;
    localparam int PERM_BIT = 6;

    localparam logic [AW-1:0] A_CMD  = 4'd0;
    localparam logic [AW-1:0] A_REQ  = 4'd1;
    localparam logic [AW-1:0] A_MODE = 4'd2;
    localparam logic [AW-1:0] A_IMG  = 4'd6;
    localparam logic [AW-1:0] A_CNT  = 4'd10;

    typedef enum logic [MW-1:0] {
        M_EVENT  = 3'd0,
        M_CAPT   = 3'd1,
        M_WAVE   = 3'd2,
        M_PULSE  = 3'd3,
        M_WDOG   = 3'd4
    } chmode_e;

    // True when the mode code selects an operating mode.
    function automatic logic mode_valid(input logic [MW-1:0] m);
        return m <= M_WDOG;
    endfunction

    // True when the mode transfers image into counter (and counts down).
    function automatic logic mode_loads(input logic [MW-1:0] m);
        return (m == M_WAVE) || (m == M_PULSE) || (m == M_WDOG);
    endfunction
endpackage

// File: rtl/ctimg_ctl_regs.sv
// Command register (write-permission bit) and load/store request register.
// Assumes: served[i] pulses for one cycle on the edge channel i transfers.
// A permitted host write replaces the request bits; otherwise served bits clear.
module ctimg_ctl_regs
    import ctimg_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_we,
    input  logic         req_we,
    input  logic [CW-1:0] wdata,
    input  logic [N-1:0] served,
    output logic         perm,
    output logic [N-1:0] req
);
    // Holds the write-permission bit of the command register.
    always_ff @(posedge clk) begin
        if (!rst_n)      perm <= 1'b0;
        else if (cmd_we) perm <= wdata[PERM_BIT];
    end

    // Accepts gated request writes and clears bits as channels serve them.
    always_ff @(posedge clk) begin
        if (!rst_n)                req <= '0;
        else if (req_we && perm)   req <= wdata[N-1:0];
        else                       req <= req & ~served;
    end
endmodule

// File: rtl/ctimg_chan.sv
// One counter channel: mode field, image register and counter.
// Assumes req is the channel's request bit. CAN_STORE = 0 removes the
// counter-to-image path so that every valid-mode request is a load.
module ctimg_chan
    import ctimg_pkg::*;
#(
    parameter int W         = CW,
    parameter bit CAN_STORE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic          img_we,
    input  logic [W-1:0]  wdata,
    input  logic          tick,
    input  logic          req,
    output logic          served,
    output logic [MW-1:0] mode,
    output logic [W-1:0]  img,
    output logic [W-1:0]  cnt
);
    logic valid, do_load, do_store;

    // Decodes the transfer direction for a pending request.
    always_comb begin
        valid    = mode_valid(mode);
        do_load  = req && valid && (mode_loads(mode) || !CAN_STORE);
        do_store = req && valid && CAN_STORE && !mode_loads(mode);
        served   = req && valid;
    end

    // Holds the channel mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (mode_we) mode <= wdata[MW-1:0];
    end

    // Image register: stores from counter, else accepts host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        img <= '0;
        else if (do_store) img <= cnt;
        else if (img_we)   img <= wdata;
    end

    // Counter: load wins over tick; direction follows the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (do_load)        cnt <= img;
        else if (tick && valid)  cnt <= mode_loads(mode) ? cnt - 1'b1 : cnt + 1'b1;
    end
endmodule

// File: rtl/ctimg_ctrl.sv
// Top: register decode, four channels and the read multiplexer.
// Assumes single-cycle host writes and combinational reads on bus_addr.
module ctimg_ctrl
    import ctimg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          tick
);
    localparam int N = NCH;
    localparam int NOSTORE_CH = 2;

    logic                 perm;
    logic [N-1:0]         req, served;
    logic [N-1:0][MW-1:0] mode;
    logic [N-1:0][CW-1:0] img, cnt;

    ctimg_ctl_regs #(.N(N)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(bus_we && bus_addr == A_CMD),
        .req_we(bus_we && bus_addr == A_REQ),
        .wdata(bus_wdata), .served(served),
        .perm(perm), .req(req)
    );

    for (genvar i = 0; i < N; i++) begin : g_ch
        ctimg_chan #(.W(CW), .CAN_STORE(i != NOSTORE_CH)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .mode_we(bus_we && bus_addr == A_MODE + AW'(i)),
            .img_we(bus_we && bus_addr == A_IMG + AW'(i)),
            .wdata(bus_wdata), .tick(tick), .req(req[i]),
            .served(served[i]), .mode(mode[i]), .img(img[i]), .cnt(cnt[i])
        );
    end

    // Selects the register addressed by bus_addr for read-back.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD) bus_rdata[PERM_BIT] = perm;
        if (bus_addr == A_REQ) bus_rdata[N-1:0] = req;
        for (int i = 0; i < N; i++) begin
            if (bus_addr == A_MODE + AW'(i)) bus_rdata[MW-1:0] = mode[i];
            if (bus_addr == A_IMG  + AW'(i)) bus_rdata = img[i];
            if (bus_addr == A_CNT  + AW'(i)) bus_rdata = cnt[i];
        end
    end
endmodule

// File: rtl/ctimg_ctrl_chk.sv
// Checker bound to ctimg_ctrl: request gating, auto-clear and transfer paths.
// Assumes the package address map and mode encoding.
module ctimg_ctrl_chk
    import ctimg_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [AW-1:0]          bus_addr,
    input logic                   perm,
    input logic [NCH-1:0]         req,
    input logic [NCH-1:0][MW-1:0] mode,
    input logic [NCH-1:0][CW-1:0] img,
    input logic [NCH-1:0][CW-1:0] cnt
);
    logic req_wr_ok, req_wr_blocked;
    assign req_wr_ok      = bus_we && bus_addr == A_REQ && perm;
    assign req_wr_blocked = bus_we && bus_addr == A_REQ && !perm;

    assert_req_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_wr_blocked) |-> (req & ~$past(req)) == '0);

    assert_ch2_nostore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we && bus_addr == A_IMG + 4'd2) |-> img[2] == $past(img[2]));

    for (genvar i = 0; i < NCH; i++) begin : g_c
        assert_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req[i] && mode_valid(mode[i]) && !req_wr_ok) |-> !req[i]);

        assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req[i] && mode_loads(mode[i])) |-> cnt[i] == $past(img[i]));

        assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!mode_valid(mode[i])) |-> cnt[i] == $past(cnt[i]));

        if (i != 2) begin : g_st
            assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(req[i] && mode_valid(mode[i]) && !mode_loads(mode[i]))
                |-> img[i] == $past(cnt[i]) && cnt[i] == $past(cnt[i]));
        end
    end
endmodule

bind ctimg_ctrl ctimg_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .perm(perm), .req(req), .mode(mode), .img(img), .cnt(cnt)
);

// File: tb/test_ctimg_ctrl.sv
module test_ctimg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick = 1'b0;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [3:0]  a;
        logic [15:0] e;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    ctimg_ctrl i_ctimg_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick)
    );

    // Monitor: pops expected reads and compares them mid-cycle.
    initial forever begin
        @(negedge clk);
        #5;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (bus_rdata !== it.e) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, bus_rdata, it.e);
            end
        end
    end

    // Driver tasks: called at a falling edge, return at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [15:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic tk();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(0, 16'h0000, "R1 cmd");
        chk(1, 16'h0000, "R1 req");
        chk(10, 16'h0000, "R1 cnt0");
        chk(6, 16'h0000, "R1 img0");
        // request without permission
        wr(6, 16'h1234); wr(2, 16'd2); wr(1, 16'h0001);
        chk(1, 16'h0000, "R2 req blocked");
        chk(1, 16'h0000, "R2 req blocked later");
        chk(10, 16'h0000, "R2 cnt0 untouched");
        wr(0, 16'h0040);
        chk(0, 16'h0040, "R2 cmd readback");
        // load ch0
        wr(1, 16'h0001);
        chk(1, 16'h0001, "R6 req pending");
        chk(1, 16'h0000, "R6 req cleared");
        chk(10, 16'h1234, "R3 load ch0");
        tk();
        chk(10, 16'h1233, "R8 count down");
        // ch1 event count, then store
        wr(3, 16'd0); tk(); tk();
        chk(11, 16'd3, "R8 count up");
        wr(1, 16'h0002);
        chk(1, 16'h0002, "R6 ch1 pending");
        chk(7, 16'd3, "R4 store ch1");
        chk(11, 16'd3, "R4 cnt1 kept");
        // ch3 time capture store
        wr(5, 16'd1); wr(1, 16'h0008);
        chk(1, 16'h0008, "R6 ch3 pending");
        chk(9, 16'd3, "R4 store ch3");
        // ch2 event mode still loads
        wr(8, 16'h0055); wr(1, 16'h0004);
        chk(1, 16'h0004, "R6 ch2 pending");
        chk(12, 16'h0055, "R5 ch2 load");
        chk(8, 16'h0055, "R5 ch2 img kept");
        // invalid mode holds request and freezes counter
        wr(2, 16'd7); wr(6, 16'h0400); wr(1, 16'h0001);
        chk(1, 16'h0001, "R7 pending");
        chk(1, 16'h0001, "R7 still pending");
        chk(10, 16'h1231, "R7 no transfer");
        tk();
        chk(10, 16'h1231, "R7 no count");
        wr(2, 16'd3);
        chk(1, 16'h0001, "R7 pending after mode write");
        chk(1, 16'h0000, "R7 served");
        chk(10, 16'h0400, "R3 pulse load");
        // transfer beats tick
        wr(1, 16'h0001); tk();
        chk(10, 16'h0400, "R9 transfer wins");
        tk();
        chk(10, 16'h03FF, "R8 pulse count down");
        // permission removed
        wr(0, 16'h0000); wr(1, 16'h0001);
        chk(1, 16'h0000, "R2 blocked again");
        chk(10, 16'h03FF, "R2 cnt0 kept");
        // upper request bits read 0
        wr(0, 16'h0040); wr(1, 16'hFFFF);
        chk(1, 16'h000F, "R10 upper bits");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule